// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block takes eight interrupt request lines and presents the most urgent one to a processor. Each line is captured into a pending register, filtered through a mask register and ranked against the levels already being serviced, held in an in-service register. When a pending, unmasked level outranks everything in service, the interrupt output rises. The processor answers with an acknowledge pulse. The controller then moves that level from pending to in-service and returns an 8-bit vector built from a programmable base and the level number.

Software drives a small register write port. Through it, software selects the trigger type of each line, sets the mask, issues end-of-interrupt commands, and picks the operating mode. The modes are fixed or rotating priority, automatic end of interrupt, special mask mode, and polled operation. In polled operation the processor reads the best pending level instead of taking an interrupt.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, int_o, vec_o and poll_o are 0, every level is masked (mask reads 8'hFF), every line is level triggered, no level is pending or in service, all mode bits are 0, the vector base is 0 and priority is fixed.
- R2: Write address 1 sets the trigger type, with bit i = 1 for edge on line i. An edge line captures a 0-to-1 transition and stays pending until it is granted, even after the line falls. A level line's pending bit copies the line one clock later while that level is not in service.
- R3: Write address 2 is the mask, with bit i = 1 blocking level i from raising int_o or being granted. The level's pending bit is kept, so clearing the mask bit raises int_o on the next cycle.
- R4: With fixed priority, level 0 is highest and level 7 lowest. int_o is high only when the best pending, unmasked level that is not in service ranks above the best in-service level, or when nothing is in service.
- R5: An ack_i pulse while a request qualifies clears that level's pending bit and sets its in-service bit. On the next cycle, vec_o = {base[7:3], level}, where base is taken from write address 3, bits 7:3.
- R6: An ack_i pulse with no qualifying request changes no pending or in-service bit. On the next cycle, vec_o = {base[7:3], 3'd7}.
- R7: A write to address 4 is an end-of-interrupt command. With data bit 3 = 1, it clears the in-service bit of the level in data bits 2:0. With data bit 3 = 0, it clears the highest-ranked in-service bit.
- R8: Mode register (address 0) bit 0 selects automatic end of interrupt: a grant then leaves the in-service register unchanged.
- R9: Mode bit 1 selects rotating priority. A level cleared by an end-of-interrupt command, or granted under automatic end of interrupt, becomes the lowest rank, and the level after it becomes the highest. Clearing the bit restores the fixed order.
- R10: Mode bit 2 selects special mask mode. In this mode, in-service levels do not block other levels: any pending, unmasked level that is not itself in service raises int_o.
- R11: Mode bit 3 selects polled mode, which holds int_o low. A write to address 5 grants as an acknowledge would. On the next cycle, poll_o = {1'b1, 4'b0, level}, or 8'h00 if nothing qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, bit i is level i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 mode, 1 trigger, 2 mask, 3 base, 4 end of interrupt, 5 poll |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge, one cycle per grant |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector latched by the last acknowledge |
| poll_o | output | 8 | Result of the last poll command |

## Verification
Pending, in-service, mask and rotation state cannot be read directly, so each of them shows up only through int_o and the vectors. A lost in-service bit lets a lower level interrupt on the very next cycle, where it should have stayed blocked. A stale pending bit yields a second vector for a request that was already served. A wrong rotation pointer names the wrong level at the next acknowledge where two levels compete. The bench therefore predicts int_o, vec_o and poll_o on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NUM_LVL  = 8;
  localparam int DATA_W   = 8;
  localparam int EOI_SPEC = 3;  // data bit marking a specific end-of-interrupt

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_TRIG = 3'd1,
    A_MASK = 3'd2,
    A_BASE = 3'd3,
    A_EOI  = 3'd4,
    A_POLL = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic poll;
    logic smm;
    logic rot;
    logic aeoi;
  } mode_t;
endpackage

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec_i,
  input  logic [$clog2(N)-1:0] hi_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] lvl_o,
  output logic [$clog2(N)-1:0] rank_o
);
  localparam int LW = $clog2(N);

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;

  // rotate so that level hi_i lands on bit 0
  assign dbl = {vec_i, vec_i} >> hi_i;
  assign rot = dbl[N-1:0];

  always_comb begin
    any_o  = 1'b0;
    rank_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        any_o  = 1'b1;
        rank_o = LW'(k);
      end
    end
  end

  assign lvl_o = rank_o + hi_i;
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] busy_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= 1'b0;
        irr_o[i]  <= 1'b0;
      end else begin
        prev_q[i] <= irq_i[i];
        if (edge_i[i]) irr_o[i] <= (irr_o[i] & ~clr_i[i]) | (irq_i[i] & ~prev_q[i]);
        else           irr_o[i] <= irq_i[i] & ~busy_i[i] & ~clr_i[i];
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter int NumLvl = NUM_LVL,
  parameter int DataW  = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumLvl-1:0] irq_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DataW-1:0]  wr_data_i,
  input  logic              ack_i,
  output logic              int_o,
  output logic [DataW-1:0]  vec_o,
  output logic [DataW-1:0]  poll_o
);
  localparam int LvlW  = $clog2(NumLvl);
  localparam int BaseW = DataW - LvlW;

  mode_t              mode_q;
  logic [NumLvl-1:0]  trig_q, imr_q, isr_q, irr_q, isr_d;
  logic [BaseW-1:0]   base_q;
  logic [LvlW-1:0]    rot_q, rot_d, hi;
  logic [DataW-1:0]   vec_q, poll_q;

  logic [NumLvl-1:0]  cand, win_oh, set_isr, eoi_oh;
  logic               win_any, isr_any, req_ok, grant, poll_wr, eoi_wr, eoi_hit;
  logic [LvlW-1:0]    win_lvl, win_rank, isr_lvl, isr_rank, eoi_lvl;

  assign hi   = mode_q.rot ? rot_q : '0;
  assign cand = irr_q & ~imr_q & ~isr_q;

  pic8_prio #(.N(NumLvl)) u_win (
    .vec_i(cand), .hi_i(hi), .any_o(win_any), .lvl_o(win_lvl), .rank_o(win_rank)
  );

  pic8_prio #(.N(NumLvl)) u_top (
    .vec_i(isr_q), .hi_i(hi), .any_o(isr_any), .lvl_o(isr_lvl), .rank_o(isr_rank)
  );

  // nesting: must outrank every in-service level unless special mask mode
  assign req_ok = win_any & (mode_q.smm | ~isr_any | (win_rank < isr_rank));
  assign int_o  = req_ok & ~mode_q.poll;

  assign poll_wr = wr_en_i && (wr_addr_i == A_POLL);
  assign eoi_wr  = wr_en_i && (wr_addr_i == A_EOI);
  assign grant   = (ack_i | poll_wr) & req_ok;
  assign win_oh  = grant ? (NumLvl'(1) << win_lvl) : '0;
  assign set_isr = mode_q.aeoi ? '0 : win_oh;

  assign eoi_lvl = wr_data_i[EOI_SPEC] ? wr_data_i[LvlW-1:0] : isr_lvl;
  assign eoi_hit = eoi_wr & (wr_data_i[EOI_SPEC] | isr_any);
  assign eoi_oh  = eoi_hit ? (NumLvl'(1) << eoi_lvl) : '0;
  assign isr_d   = (isr_q | set_isr) & ~eoi_oh;

  always_comb begin
    rot_d = rot_q;
    if (grant && mode_q.aeoi && mode_q.rot) rot_d = win_lvl + 1'b1;
    if (eoi_hit && mode_q.rot)              rot_d = eoi_lvl + 1'b1;
  end

  pic8_req #(.N(NumLvl)) u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .edge_i(trig_q),
    .clr_i (win_oh),
    .busy_i(isr_d),
    .irr_o (irr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      trig_q <= '0;
      imr_q  <= '1;
      base_q <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
      vec_q  <= '0;
      poll_q <= '0;
    end else begin
      isr_q <= isr_d;
      rot_q <= rot_d;
      if (ack_i) vec_q <= {base_q, (grant ? win_lvl : {LvlW{1'b1}})};
      if (poll_wr) poll_q <= req_ok ? {1'b1, {(DataW-1-LvlW){1'b0}}, win_lvl} : '0;
      if (wr_en_i) begin
        case (wr_addr_i)
          A_MODE:  mode_q <= mode_t'(wr_data_i[3:0]);
          A_TRIG:  trig_q <= wr_data_i[NumLvl-1:0];
          A_MASK:  imr_q  <= wr_data_i[NumLvl-1:0];
          A_BASE:  base_q <= wr_data_i[DataW-1:LvlW];
          default: ;
        endcase
      end
    end
  end

  assign vec_o  = vec_q;
  assign poll_o = poll_q;
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
  parameter int NumLvl = 8,
  parameter int DataW  = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          int_o,
  input logic                          ack_i,
  input logic                          wr_en_i,
  input logic                          aeoi,
  input logic                          poll_mode,
  input logic [NumLvl-1:0]             irr,
  input logic [NumLvl-1:0]             imr,
  input logic [NumLvl-1:0]             isr,
  input logic [DataW-$clog2(NumLvl)-1:0] base,
  input logic [DataW-1:0]              vec_o
);
  localparam int LvlW = $clog2(NumLvl);

  // R3
  int_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));

  // R5
  ack_to_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !aeoi && !wr_en_i) |=> isr[vec_o[LvlW-1:0]]);

  // R5
  vec_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (vec_o[DataW-1:LvlW] == $past(base)));

  // R6
  spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !poll_mode && !wr_en_i) |=> ((vec_o[LvlW-1:0] == '1) && $stable(isr)));

  // R8
  aeoi_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi && !wr_en_i) |=> $stable(isr));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.NumLvl(NumLvl), .DataW(DataW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_o    (int_o),
  .ack_i    (ack_i),
  .wr_en_i  (wr_en_i),
  .aeoi     (mode_q.aeoi),
  .poll_mode(mode_q.poll),
  .irr      (irr_q),
  .imr      (imr_q),
  .isr      (isr_q),
  .base     (base_q),
  .vec_o    (vec_o)
);

// File: tb/pic8_ctrl_bench.sv
module pic8_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       int_o;
  logic [7:0] vec_o, poll_o;

  int errors = 0;
  int checks = 0;
  string cur = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic8_ctrl u_pic8_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ack_i(ack), .int_o(int_o), .vec_o(vec_o), .poll_o(poll_o)
  );

  // behavioural reference
  bit [7:0] m_irr, m_isr, m_imr, m_trig, m_prev, m_base, m_vec, m_poll;
  bit m_aeoi, m_rot_en, m_smm, m_pollm;
  int m_rot;

  function automatic int hb();
    return m_rot_en ? m_rot : 0;
  endfunction

  function automatic int best(bit [7:0] v);
    for (int k = 0; k < 8; k++) if (v[(hb() + k) % 8]) return (hb() + k) % 8;
    return -1;
  endfunction

  function automatic int rank(int l);
    return (l - hb() + 8) % 8;
  endfunction

  function automatic bit qualifies(output int w);
    int t;
    w = best(m_irr & ~m_imr & ~m_isr);
    if (w < 0) return 1'b0;
    if (m_smm) return 1'b1;
    t = best(m_isr);
    if (t < 0) return 1'b1;
    return rank(w) < rank(t);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_trig = 0; m_prev = 0; m_base = 0;
      m_vec = 0; m_poll = 0; m_aeoi = 0; m_rot_en = 0; m_smm = 0; m_pollm = 0; m_rot = 0;
    end else begin
      int w, l, n_rot;
      bit ok, pw, gr;
      bit [7:0] n_isr, clr;
      ok = qualifies(w);
      pw = wr_en && wr_addr == 3'd5;
      gr = (ack || pw) && ok;
      n_isr = m_isr; clr = 0; n_rot = m_rot;
      if (ack) m_vec = {m_base[7:3], gr ? 3'(w) : 3'd7};
      if (pw) m_poll = ok ? (8'h80 | 8'(w)) : 8'h00;
      if (gr) begin
        clr[w] = 1'b1;
        if (!m_aeoi) n_isr[w] = 1'b1;
        else if (m_rot_en) n_rot = (w + 1) % 8;
      end
      if (wr_en && wr_addr == 3'd4) begin
        l = wr_data[3] ? int'(wr_data[2:0]) : best(m_isr);
        if (l >= 0) begin
          n_isr[l] = 1'b0;
          if (m_rot_en) n_rot = (l + 1) % 8;
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (m_trig[i]) m_irr[i] = (m_irr[i] & ~clr[i]) | (irq[i] & ~m_prev[i]);
        else           m_irr[i] = irq[i] & ~n_isr[i] & ~clr[i];
      end
      m_prev = irq;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_aeoi = wr_data[0]; m_rot_en = wr_data[1]; m_smm = wr_data[2]; m_pollm = wr_data[3]; end
          3'd1: m_trig = wr_data;
          3'd2: m_imr = wr_data;
          3'd3: m_base = wr_data & 8'hF8;
          default: ;
        endcase
      end
      m_isr = n_isr;
      m_rot = n_rot;
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int w;
      bit ok;
      ok = qualifies(w);
      check(rst_n ? cur : "R1", "int_o", {7'b0, int_o}, {7'b0, ok && !m_pollm});
      check(rst_n ? cur : "R1", "vec_o", vec_o, m_vec);
      check(rst_n ? cur : "R1", "poll_o", poll_o, m_poll);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    check("R1", "reset int_o", {7'b0, int_o}, 8'h00);
    check("R1", "reset vec_o", vec_o, 8'h00);
    rst_n = 1'b1;
    idle(2);
    // R1: all masked after reset, so a raised line must not interrupt
    irq = 8'h01; idle(3);
    check("R1", "masked after reset", {7'b0, int_o}, 8'h00);
    irq = 8'h00; idle(1);

    cur = "R4";
    wr(3'd3, 8'h40); wr(3'd2, 8'h00);
    irq = 8'b0010_0100; idle(2);
    check("R4", "int with requests", {7'b0, int_o}, 8'h01);
    cur = "R5"; do_ack();
    check("R5", "vector level 2", vec_o, 8'h42);
    cur = "R4"; idle(1);
    check("R4", "lower level blocked", {7'b0, int_o}, 8'h00);
    irq[2] = 1'b0;
    cur = "R7"; wr(3'd4, 8'h00); idle(1);
    check("R7", "nonspecific eoi frees level 5", {7'b0, int_o}, 8'h01);
    do_ack();
    check("R5", "vector level 5", vec_o, 8'h45);
    irq = 8'h00; wr(3'd4, 8'h0D); idle(2);

    cur = "R3";
    wr(3'd2, 8'h08); irq[3] = 1'b1; idle(3);
    check("R3", "masked level", {7'b0, int_o}, 8'h00);
    wr(3'd2, 8'h00);
    check("R3", "unmasked level", {7'b0, int_o}, 8'h01);
    do_ack(); irq = 8'h00; wr(3'd4, 8'h0B); idle(1);

    cur = "R2";
    wr(3'd1, 8'hFF); pulse(8'h40); idle(3);
    check("R2", "edge held", {7'b0, int_o}, 8'h01);
    do_ack();
    check("R2", "edge vector", vec_o, 8'h46);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00); pulse(8'h02); idle(2);
    check("R2", "level follows line", {7'b0, int_o}, 8'h00);

    cur = "R6";
    do_ack();
    check("R6", "spurious vector", vec_o, 8'h47);

    cur = "R8";
    wr(3'd1, 8'hFF); wr(3'd0, 8'h01);
    pulse(8'h10); do_ack();
    pulse(8'h20); idle(1);
    check("R8", "no in-service after auto eoi", {7'b0, int_o}, 8'h01);
    do_ack();
    check("R8", "auto eoi vector", vec_o, 8'h45);

    cur = "R9";
    wr(3'd0, 8'h03);
    pulse(8'h01); do_ack();
    pulse(8'h09); do_ack();
    check("R9", "rotated winner", vec_o, 8'h43);
    do_ack();
    check("R9", "rotated second", vec_o, 8'h40);
    wr(3'd0, 8'h02);
    pulse(8'h81); do_ack();
    wr(3'd4, 8'h00); idle(1);
    do_ack(); wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    pulse(8'h81); do_ack();
    check("R9", "fixed order restored", vec_o, 8'h40);
    wr(3'd4, 8'h00); do_ack(); wr(3'd4, 8'h00); idle(1);

    cur = "R10";
    wr(3'd0, 8'h04);
    pulse(8'h20); do_ack();
    pulse(8'h40); idle(1);
    check("R10", "lower level passes in-service", {7'b0, int_o}, 8'h01);
    do_ack();
    check("R10", "special mask vector", vec_o, 8'h46);
    wr(3'd4, 8'h0D); wr(3'd4, 8'h0E); wr(3'd0, 8'h00);

    cur = "R11";
    wr(3'd0, 8'h08);
    pulse(8'h04); idle(2);
    check("R11", "int held low", {7'b0, int_o}, 8'h00);
    wr(3'd5, 8'h00);
    check("R11", "poll result", poll_o, 8'h82);
    wr(3'd5, 8'h00);
    check("R11", "empty poll", poll_o, 8'h00);
    wr(3'd4, 8'h00); wr(3'd0, 8'h00);

    // mixed traffic checked against the reference every clock
    cur = "R4";
    wr(3'd1, 8'hA5);
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      irq = 8'($urandom);
      ack = ($urandom % 5) == 0;
      wr_en = ($urandom % 7) == 0;
      wr_addr = ($urandom % 3 == 0) ? 3'd0 : 3'd4;
      wr_data = (wr_addr == 3'd0) ? 8'($urandom % 8) : 8'($urandom % 16);
      cur = (wr_data[1]) ? "R9" : "R4";
    end
    @(negedge clk); ack = 1'b0; wr_en = 1'b0; irq = 8'h00;
    idle(3);
    finish_run();
  end
endmodule